// File: doc/BRIEF.md
# Multi-channel hit priority selector

This block gathers hit addresses from 32 front-end chips. Each chip sends one short serial frame on its own wire per bunch crossing. A common crossing strobe marks where every frame starts. Each frame is turned into a hit flag and a 6-bit strip address. Once per crossing, up to eight flagged channels are picked in fixed priority, with the lowest channel number first.

Each picked hit becomes an 11-bit word: the 5-bit chip number in front of the 6-bit strip address. The block keeps a 12-bit crossing counter and stamps its value on every output frame. The output is presented as a wide parallel word for a downstream serializer. A status bit reports when more hits arrived than the eight slots can hold.

A synchronous crossing-reset input returns the counter to zero. The block runs on the fast capture clock, one serial bit per cycle.

Top module: `hit_priority_selector`

## Requirements
- R1: A frame on each `ser_in` bit lasts 8 cycles. The cycle in which `bc_strobe` is sampled high carries the hit flag (1 = hit). The next six cycles carry the strip address, most significant bit first. The last cycle is idle and its value is not used.
- R2: `out_valid` is high for exactly one cycle. That cycle begins at the clock edge 7 edges after the edge that sampled `bc_strobe`. The data outputs keep their values until the next such edge.
- R3: Slot k of `out_slots` occupies bits [11k+10:11k] and holds {chip number[4:0], strip address[5:0]}. Flagged channels fill the slots in ascending channel order, starting at slot 0.
- R4: `out_slot_vld[k]` is 1 exactly when slot k holds a hit. The valid bits form a contiguous run from bit 0, and an unused slot's data bits are zero.
- R5: When more than 8 channels flag a hit in one crossing, `out_overflow` is 1, slots 0 to 7 hold the 8 lowest-numbered flagged channels, and the rest are dropped. With 8 or fewer hits, `out_overflow` is 0.
- R6: Each crossing is stamped on `out_bcid` with the current count. The count then advances by one per strobe and wraps from 4095 to 0.
- R7: `bc_reset` clears the count to zero. If it coincides with a strobe, that crossing is stamped 0 and the next crossing is stamped 1.
- R8: After `rst_n` is released, and before the first frame completes, all outputs are zero.
- R9: A channel whose flag bit is 0 contributes nothing to any output, whatever its address bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast capture clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bc_strobe | input | 1 | High in the flag-bit cycle of each crossing |
| bc_reset | input | 1 | Synchronous clear of the crossing counter |
| ser_in | input | 32 | One serial hit stream per front-end chip |
| out_valid | output | 1 | One-cycle pulse when a new frame is on the outputs |
| out_slots | output | 88 | Eight 11-bit hit words, slot 0 in the low bits |
| out_slot_vld | output | 8 | Per-slot valid bits |
| out_bcid | output | 12 | Crossing number of the frame |
| out_overflow | output | 1 | More hits than slots in this crossing |

## Verification
A frame's result is due on the 7th edge after the edge that samples its strobe. It is seen at the falling edge that follows that edge. The stamped crossing number and overflow bit appear in the same cycle as the slots. The bench stamps each expected frame with the cycle in which it must appear. The monitor samples only at falling edges and compares that stamp with its own cycle count, so a frame that arrives early or late fails even when its contents are right. After the last frame the queue must drain, which catches a frame that never appears.

// File: rtl/hps_pkg.sv
package hps_pkg;
   localparam int unsigned HPS_NUM_CH_DEF = 32;
   localparam int unsigned HPS_ADDR_W_DEF = 6;
   localparam int unsigned HPS_SLOTS_DEF  = 8;
   localparam int unsigned HPS_BCID_W_DEF = 12;
endpackage

// File: rtl/hps_deser.sv
module hps_deser #(
   parameter int unsigned WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_in,
   output logic [WIDTH-1:0] shreg
);
   // newest bit enters at bit 0, so the first bit of a frame ends up at the top
   always_ff @(posedge clk) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[WIDTH-2:0], ser_in};
   end
endmodule

// File: rtl/hps_frame_ctrl.sv
module hps_frame_ctrl #(
   parameter int unsigned FRAME_LEN = 8,
   parameter int unsigned BCID_W    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bc_strobe,
   input  logic              bc_reset,
   output logic              capture,
   output logic [BCID_W-1:0] frame_bcid
);
   localparam int unsigned PH_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
   localparam logic [PH_W-1:0] LAST = PH_W'(FRAME_LEN - 1);

   logic [PH_W-1:0]   ph_q;
   logic              run_q;
   logic [BCID_W-1:0] cnt_q, base;

   assign base    = bc_reset ? '0 : cnt_q;
   assign capture = run_q && (ph_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q       <= '0;
         run_q      <= 1'b0;
         cnt_q      <= '0;
         frame_bcid <= '0;
      end else if (bc_strobe) begin
         ph_q       <= PH_W'(1);
         run_q      <= 1'b1;
         frame_bcid <= base;
         cnt_q      <= base + 1'b1;
      end else begin
         cnt_q <= base;
         if (run_q) begin
            ph_q <= ph_q + 1'b1;
            if (ph_q == LAST) run_q <= 1'b0;
         end
      end
   end

   assert_bcid_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_strobe && !bc_reset) |=> (cnt_q == $past(cnt_q) + 1'b1));
   assert_bcid_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_reset && !bc_strobe) |=> (cnt_q == '0));
   assert_bcid_zero_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_reset && bc_strobe) |=> (frame_bcid == '0));
   assert_capture_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !capture);
endmodule

// File: rtl/hps_select.sv
module hps_select #(
   parameter int unsigned NUM_CH = 32,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned SLOTS  = 8,
   parameter int unsigned CH_W   = 5
) (
   input  logic [NUM_CH-1:0]               flags,
   input  logic [NUM_CH*ADDR_W-1:0]        addrs,
   output logic [SLOTS*(CH_W+ADDR_W)-1:0]  slot_data,
   output logic [SLOTS-1:0]                slot_vld,
   output logic                            overflow
);
   localparam int unsigned SW    = CH_W + ADDR_W;
   localparam int unsigned CNT_W = $clog2(NUM_CH + 1);

   // rank[c] = number of flagged channels below channel c
   logic [CNT_W-1:0] rank [NUM_CH+1];

   always_comb begin
      rank[0] = '0;
      for (int c = 0; c < NUM_CH; c++)
         rank[c+1] = rank[c] + CNT_W'(flags[c]);
   end

   assign overflow = (rank[NUM_CH] > CNT_W'(SLOTS));

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      logic          vld;
      logic [SW-1:0] dat;
      always_comb begin
         vld = 1'b0;
         dat = '0;
         for (int c = 0; c < NUM_CH; c++) begin
            if (flags[c] && (rank[c] == CNT_W'(k))) begin
               vld = 1'b1;
               dat = dat | {CH_W'(c), addrs[c*ADDR_W +: ADDR_W]};
            end
         end
      end
      assign slot_vld[k]           = vld;
      assign slot_data[k*SW +: SW] = dat;
   end
endmodule

// File: rtl/hit_priority_selector.sv
module hit_priority_selector
   import hps_pkg::*;
#(
   parameter int unsigned NUM_CH = HPS_NUM_CH_DEF,
   parameter int unsigned ADDR_W = HPS_ADDR_W_DEF,
   parameter int unsigned SLOTS  = HPS_SLOTS_DEF,
   parameter int unsigned BCID_W = HPS_BCID_W_DEF
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    bc_strobe,
   input  logic                                    bc_reset,
   input  logic [NUM_CH-1:0]                       ser_in,
   output logic                                    out_valid,
   output logic [SLOTS*($clog2(NUM_CH)+ADDR_W)-1:0] out_slots,
   output logic [SLOTS-1:0]                        out_slot_vld,
   output logic [BCID_W-1:0]                       out_bcid,
   output logic                                    out_overflow
);
   localparam int unsigned CH_W      = $clog2(NUM_CH);
   localparam int unsigned SW        = CH_W + ADDR_W;
   localparam int unsigned FRAME_LEN = ADDR_W + 2;   // flag, address, idle

   if (NUM_CH < 2 || ADDR_W < 1 || BCID_W < 1 || SLOTS < 2 || SLOTS > NUM_CH) begin : g_bad_cfg
      $error("hit_priority_selector: unsupported parameter set");
   end

   logic                      capture;
   logic [BCID_W-1:0]         frame_bcid;
   logic [NUM_CH-1:0]         flags;
   logic [NUM_CH*ADDR_W-1:0]  addrs;
   logic [SLOTS*SW-1:0]       sel_data;
   logic [SLOTS-1:0]          sel_vld;
   logic                      sel_ovf;

   hps_frame_ctrl #(.FRAME_LEN(FRAME_LEN), .BCID_W(BCID_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bc_strobe(bc_strobe), .bc_reset(bc_reset),
      .capture(capture), .frame_bcid(frame_bcid));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [ADDR_W:0] sh;
      hps_deser #(.WIDTH(ADDR_W + 1)) u_deser (
         .clk(clk), .rst_n(rst_n), .ser_in(ser_in[c]), .shreg(sh));
      assign flags[c]                    = sh[ADDR_W];
      assign addrs[c*ADDR_W +: ADDR_W]   = sh[ADDR_W-1:0];
   end

   hps_select #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SLOTS(SLOTS), .CH_W(CH_W)) u_sel (
      .flags(flags), .addrs(addrs), .slot_data(sel_data),
      .slot_vld(sel_vld), .overflow(sel_ovf));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_slots    <= '0;
         out_slot_vld <= '0;
         out_bcid     <= '0;
         out_overflow <= 1'b0;
      end else begin
         out_valid <= capture;
         if (capture) begin
            out_slots    <= sel_data;
            out_slot_vld <= sel_vld;
            out_bcid     <= frame_bcid;
            out_overflow <= sel_ovf;
         end
      end
   end

   assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   assert_vld_contig_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_slot_vld & (out_slot_vld + 1'b1)) == '0));
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_overflow |-> (&out_slot_vld));
   for (genvar k = 0; k + 1 < SLOTS; k++) begin : g_order_chk
      assert_slot_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
         out_slot_vld[k+1] |->
            (out_slots[k*SW + ADDR_W +: CH_W] < out_slots[(k+1)*SW + ADDR_W +: CH_W]));
   end
endmodule

// File: tb/hit_priority_selector_tb.sv
module hit_priority_selector_tb_top;
   localparam int NCH = 32;
   localparam int AW  = 6;
   localparam int NS  = 8;
   localparam int BW  = 12;
   localparam int SW  = 11;

   logic              clk = 1'b0;
   logic              rst_n, bc_strobe, bc_reset;
   logic [NCH-1:0]    ser_in;
   logic              out_valid, out_overflow;
   logic [NS*SW-1:0]  out_slots;
   logic [NS-1:0]     out_slot_vld;
   logic [BW-1:0]     out_bcid;

   always #5 clk = ~clk;

   hit_priority_selector dut_i (
      .clk(clk), .rst_n(rst_n), .bc_strobe(bc_strobe), .bc_reset(bc_reset),
      .ser_in(ser_in), .out_valid(out_valid), .out_slots(out_slots),
      .out_slot_vld(out_slot_vld), .out_bcid(out_bcid), .out_overflow(out_overflow));

   typedef struct {
      longint          due;
      logic [NS*SW-1:0] slots;
      logic [NS-1:0]   vld;
      logic [BW-1:0]   bcid;
      logic            ovf;
   } exp_t;

   exp_t   exp_q[$];
   int     checks = 0, errors = 0;
   longint cyc = 0;
   int     model_bcid = 0;
   bit     finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string what, input logic [95:0] act, input logic [95:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, expv);
      end
   endtask

   function automatic logic [NCH*AW-1:0] mk_addr(input int seed);
      logic [NCH*AW-1:0] a;
      for (int c = 0; c < NCH; c++) a[c*AW +: AW] = AW'((c * 13 + seed) & 63);
      return a;
   endfunction

   // driver: pushes the expected frame, then serializes it
   task automatic send_frame(input logic [NCH-1:0] fl, input logic [NCH*AW-1:0] ad, input bit brst);
      exp_t e;
      int   n, base;
      @(negedge clk);
      base = brst ? 0 : model_bcid;
      e.bcid = BW'(base);
      model_bcid = (base + 1) & 12'hFFF;
      e.slots = '0; e.vld = '0; n = 0;
      for (int c = 0; c < NCH; c++) begin
         if (fl[c]) begin
            if (n < NS) begin
               e.slots[n*SW +: SW] = {5'(c), ad[c*AW +: AW]};
               e.vld[n] = 1'b1;
            end
            n++;
         end
      end
      e.ovf = (n > NS);
      e.due = cyc + 8;
      exp_q.push_back(e);
      bc_strobe = 1'b1; bc_reset = brst; ser_in = fl;
      for (int b = AW - 1; b >= 0; b--) begin
         @(negedge clk);
         bc_strobe = 1'b0; bc_reset = 1'b0;
         for (int c = 0; c < NCH; c++) ser_in[c] = ad[c*AW + b];
      end
      @(negedge clk);
      ser_in = '1;   // idle bit, driven high on purpose: it must be ignored (R1)
   endtask

   task automatic pulse_bcreset();
      @(negedge clk);
      ser_in = '0; bc_reset = 1'b1;
      @(negedge clk);
      bc_reset = 1'b0;
      model_bcid = 0;
   endtask

   // monitor: pops and compares when the design presents a frame
   always @(negedge clk) begin
      if (rst_n && !finished && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected out_valid", 96'(cyc), 96'(0));
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(cyc == e.due, "R2 frame timing cycle", 96'(cyc), 96'(e.due));
            check(out_slots == e.slots, "R1/R3/R9 slot data", 96'(out_slots), 96'(e.slots));
            check(out_slot_vld == e.vld, "R4 slot valid bits", 96'(out_slot_vld), 96'(e.vld));
            check(out_overflow == e.ovf, "R5 overflow", 96'(out_overflow), 96'(e.ovf));
            check(out_bcid == e.bcid, "R6/R7 crossing number", 96'(out_bcid), 96'(e.bcid));
         end
      end
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; bc_strobe = 1'b0; bc_reset = 1'b0; ser_in = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state at the ports
      check(out_valid == 1'b0, "R8 reset out_valid", 96'(out_valid), 96'(0));
      check(out_slots == '0, "R8 reset out_slots", 96'(out_slots), 96'(0));
      check(out_slot_vld == '0, "R8 reset out_slot_vld", 96'(out_slot_vld), 96'(0));
      check(out_bcid == '0, "R8 reset out_bcid", 96'(out_bcid), 96'(0));
      check(out_overflow == 1'b0, "R8 reset out_overflow", 96'(out_overflow), 96'(0));

      send_frame(32'h0000_0000, mk_addr(1), 1'b0);   // no hits
      send_frame(32'h8000_0000, '1, 1'b0);           // R3 top channel, address 63
      send_frame(32'h0002_0021, mk_addr(5), 1'b0);   // R3 channels 0, 5, 17
      send_frame(32'h8888_8888, mk_addr(9), 1'b0);   // R5 exactly eight hits
      send_frame(32'h0000_01FF, mk_addr(2), 1'b0);   // R5 nine hits, overflow
      send_frame(32'hFFFF_FFFF, mk_addr(3), 1'b0);   // R5 all channels
      send_frame(32'h0000_0000, '1, 1'b0);           // R9 addresses without flags
      send_frame(32'h0001_0000, '1, 1'b0);           // R9 one flag among noisy addresses
      send_frame(32'h4000_0002, mk_addr(7), 1'b1);   // R7 reset with strobe
      send_frame(32'h0000_0400, mk_addr(8), 1'b0);   // R7 next crossing is 1
      pulse_bcreset();                               // R7 reset alone
      send_frame(32'hF000_000F, mk_addr(4), 1'b0);
      // R6 long run past the counter wrap
      for (int i = 0; i < 4100; i++)
         send_frame(NCH'(i * 32'h0101_1011) ^ NCH'(i << 20), mk_addr(i), 1'b0);

      for (int w = 0; w < 40 && exp_q.size() != 0; w++) @(negedge clk);
      check(exp_q.size() == 0, "R2 missing frames", 96'(exp_q.size()), 96'(0));
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule